// File: doc/BRIEF.md
# Gain-Normalizing Offset-Corrected Decimator

This block sits behind a successive-approximation converter whose analog front end switches between a gain of 1 and a gain of 100. Every incoming 16-bit signed code carries a one-bit tag saying which gain was active when it was converted. The block brings each code onto the high-gain code scale by multiplying low-gain codes by 100. It then subtracts a zero offset picked by that sample's own tag, sums 72 corrected samples and divides the sum by 72. The 23-bit average is presented with a one-cycle ready pulse, so results come out at one seventy-second of the sample rate.

Offsets are learned on the same datapath. While the calibration input is high, samples pass uncorrected. A block made only of calibration samples that all share one gain tag writes its average into that gain's offset register when its result appears. The division is a bit-serial restoring divider with three named states: DV_IDLE (waiting; go moves it to DV_RUN), DV_RUN (one quotient bit per cycle; after the last bit it moves to DV_FIX) and DV_FIX (sign restore and clamp; always returns to DV_IDLE). The next block keeps accumulating while the divider works.

Top module: `gain_norm_decim`

## Requirements
- R1: Reset clears both offsets, any partial sum and the sample count, and drives out_valid to 0 and out_data to 0; the first full block after reset is averaged with zero offsets.
- R2: A sample tagged in_gain_hi=0 (gain 1) enters the sum as its code times 100; a sample tagged in_gain_hi=1 (gain 100) enters unscaled.
- R3: Outside calibration, each sample has subtracted the offset of its own gain tag (low offset for tag 0, high offset for tag 1), so blocks with tags changing sample by sample are corrected per sample.
- R4: Only cycles with in_valid=1 count; every 72 valid samples produce exactly one result, and the sum restarts from zero for the next block.
- R5: The result is the block sum divided by 72, truncated toward zero (a sum of -2628 gives -36).
- R6: out_valid is a one-cycle pulse 35 clock cycles after the cycle that presented the 72nd sample; out_data changes only together with out_valid and holds between pulses.
- R7: With in_cal=1 no offset is subtracted; a block whose 72 samples all have in_cal=1 and one common gain tag stores its result as that gain's offset, used by samples presented after the cycle in which that result's out_valid is high.
- R8: A block that mixes gain tags, or that is not entirely calibration samples, leaves both offsets unchanged.
- R9: Averages above 4194303 give 4194303 and averages below -4194304 give -4194304.
- R10: Samples presented on every cycle, back to back across block boundaries, each yield a correct result while the previous division is still in progress.

Port table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A converter sample is present this cycle |
| in_sample | input | 16 | Signed converter code |
| in_gain_hi | input | 1 | Gain tag of the sample: 0 = gain 1, 1 = gain 100 |
| in_cal | input | 1 | Sample belongs to offset calibration |
| out_valid | output | 1 | One-cycle pulse: new average on out_data |
| out_data | output | 23 | Signed average on the gain-100 code scale |

## Verification
Two events can land in the same cycle. An offset write at the end of a calibration division can coincide with a sample of the following block entering correction. A block handoff can coincide with the divider still owning the previous sum. The bench streams blocks back to back, so the result of a calibration block always appears 35 samples into the next block, and in one case that next block mixes gain tags. The bench judges both events against its own model, which switches offsets exactly after the cycle in which out_valid is seen. It also checks that every result arrives on its predicted cycle while the next block is being summed.

// File: rtl/gnd_pkg.sv
package gnd_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIX  = 2'd2
    } dv_state_t;

endpackage

// File: rtl/gnd_front.sv
// Front stage: scale to the high-gain code scale and remove the per-gain offset.
module gnd_front #(
    parameter int IN_W   = 16,
    parameter int RATIO  = 100,
    parameter int NORM_W = 23
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    input  logic                     in_gain_hi,
    input  logic                     in_cal,
    input  logic signed [NORM_W-1:0] off_lo,
    input  logic signed [NORM_W-1:0] off_hi,
    output logic                     s1_valid,
    output logic signed [NORM_W:0]   s1_corr,
    output logic                     s1_gain_hi,
    output logic                     s1_cal
);
    localparam int CORR_W = NORM_W + 1;
    localparam logic signed [NORM_W-1:0] RATIO_C = NORM_W'(RATIO);

    logic signed [NORM_W-1:0] ext;
    logic signed [NORM_W-1:0] norm;
    logic signed [NORM_W-1:0] off_sel;
    logic signed [CORR_W-1:0] corr;

    always_comb begin
        ext     = NORM_W'(in_sample);
        norm    = in_gain_hi ? ext : ext * RATIO_C;
        off_sel = in_gain_hi ? off_hi : off_lo;
        corr    = CORR_W'(norm) - (in_cal ? CORR_W'(0) : CORR_W'(off_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_corr    <= '0;
            s1_gain_hi <= 1'b0;
            s1_cal     <= 1'b0;
        end else begin
            s1_valid   <= in_valid;
            s1_corr    <= corr;
            s1_gain_hi <= in_gain_hi;
            s1_cal     <= in_cal;
        end
    end
endmodule

// File: rtl/gnd_accum.sv
// Block accumulator: sums BLOCK_LEN corrected samples and hands the sum over.
module gnd_accum #(
    parameter int CORR_W    = 24,
    parameter int BLOCK_LEN = 72,
    parameter int SUM_W     = 31
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    s1_valid,
    input  logic signed [CORR_W-1:0] s1_corr,
    input  logic                    s1_gain_hi,
    input  logic                    s1_cal,
    output logic                    blk_go,
    output logic signed [SUM_W-1:0] blk_sum,
    output logic                    blk_cal_ok,
    output logic                    blk_gain_hi
);
    localparam int CNT_W = $clog2(BLOCK_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] acc_nx;
    logic [CNT_W-1:0]        cnt;
    logic                    ref_gain;
    logic                    all_cal;
    logic                    uniform;
    logic                    first;
    logic                    gain_nx;
    logic                    cal_nx;
    logic                    uni_nx;

    always_comb begin
        first   = (cnt == '0);
        gain_nx = first ? s1_gain_hi : ref_gain;
        cal_nx  = (first | all_cal) & s1_cal;
        uni_nx  = (first | uniform) & (s1_gain_hi == gain_nx);
        acc_nx  = acc + SUM_W'(s1_corr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc         <= '0;
            cnt         <= '0;
            ref_gain    <= 1'b0;
            all_cal     <= 1'b0;
            uniform     <= 1'b0;
            blk_go      <= 1'b0;
            blk_sum     <= '0;
            blk_cal_ok  <= 1'b0;
            blk_gain_hi <= 1'b0;
        end else begin
            blk_go <= 1'b0;
            if (s1_valid) begin
                if (cnt == LAST) begin
                    blk_go      <= 1'b1;
                    blk_sum     <= acc_nx;
                    blk_cal_ok  <= cal_nx & uni_nx;
                    blk_gain_hi <= gain_nx;
                    acc         <= '0;
                    cnt         <= '0;
                end else begin
                    acc <= acc_nx;
                    cnt <= cnt + 1'b1;
                end
                ref_gain <= gain_nx;
                all_cal  <= cal_nx;
                uniform  <= uni_nx;
            end
        end
    end
endmodule

// File: rtl/gnd_divider.sv
// Bit-serial restoring divider by a constant, truncating toward zero, clamped output.
module gnd_divider
    import gnd_pkg::*;
#(
    parameter int SUM_W = 31,
    parameter int DEN   = 72,
    parameter int OUT_W = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic signed [SUM_W-1:0] sum,
    output logic                    idle,
    output logic                    done,
    output logic signed [OUT_W-1:0] quot
);
    localparam int DEN_W  = $clog2(DEN + 1);
    localparam int STEP_W = $clog2(SUM_W);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SUM_W - 1);
    localparam logic [DEN_W:0]    DEN_C     = (DEN_W + 1)'(DEN);
    localparam logic [SUM_W-1:0]  POS_LIM   = SUM_W'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic [SUM_W-1:0]  NEG_LIM   = SUM_W'(64'd1 << (OUT_W - 1));
    localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    dv_state_t state;
    dv_state_t nxt;

    logic [SUM_W-1:0]  mag;
    logic [DEN_W-1:0]  rem;
    logic [STEP_W-1:0] step;
    logic              neg;
    logic [DEN_W:0]    trial;
    logic              qbit;
    logic [DEN_W:0]    trial_sub;
    logic signed [SUM_W-1:0] sq;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= DV_IDLE;
        else     state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            DV_IDLE: if (go) nxt = DV_RUN;
            DV_RUN:  if (step == STEP_LAST) nxt = DV_FIX;
            DV_FIX:  nxt = DV_IDLE;
            default: nxt = DV_IDLE;
        endcase
    end

    always_comb begin
        trial     = {rem, mag[SUM_W-1]};
        qbit      = (trial >= DEN_C);
        trial_sub = trial - DEN_C;
        sq        = neg ? -$signed(mag) : $signed(mag);
        idle      = (state == DV_IDLE);
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            mag  <= '0;
            rem  <= '0;
            step <= '0;
            neg  <= 1'b0;
            done <= 1'b0;
            quot <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                DV_IDLE: begin
                    if (go) begin
                        neg  <= sum[SUM_W-1];
                        mag  <= sum[SUM_W-1] ? SUM_W'(-sum) : SUM_W'(sum);
                        rem  <= '0;
                        step <= '0;
                    end
                end
                DV_RUN: begin
                    rem  <= qbit ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
                    mag  <= {mag[SUM_W-2:0], qbit};
                    step <= step + 1'b1;
                end
                DV_FIX: begin
                    done <= 1'b1;
                    if (!neg && mag > POS_LIM)     quot <= OUT_MAX;
                    else if (neg && mag > NEG_LIM) quot <= OUT_MIN;
                    else                           quot <= sq[OUT_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gain_norm_decim.sv
// Top: gain normalization, per-gain offset removal, block averaging, offset learning.
module gain_norm_decim #(
    parameter int IN_W      = 16,
    parameter int RATIO     = 100,
    parameter int BLOCK_LEN = 72,
    localparam int OUT_W    = IN_W + $clog2(RATIO)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_sample,
    input  logic                    in_gain_hi,
    input  logic                    in_cal,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int NORM_W = OUT_W;
    localparam int CORR_W = NORM_W + 1;
    localparam int SUM_W  = CORR_W + $clog2(BLOCK_LEN);

    logic signed [NORM_W-1:0] off_lo;
    logic signed [NORM_W-1:0] off_hi;
    logic                     s1_valid;
    logic signed [CORR_W-1:0] s1_corr;
    logic                     s1_gain_hi;
    logic                     s1_cal;
    logic                     blk_go;
    logic signed [SUM_W-1:0]  blk_sum;
    logic                     blk_cal_ok;
    logic                     blk_gain_hi;
    logic                     div_idle;
    logic                     div_done;
    logic signed [OUT_W-1:0]  div_quot;
    logic                     pend_cal;
    logic                     pend_gain_hi;

    gnd_front #(.IN_W(IN_W), .RATIO(RATIO), .NORM_W(NORM_W)) u_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_gain_hi(in_gain_hi), .in_cal(in_cal), .off_lo(off_lo), .off_hi(off_hi),
        .s1_valid(s1_valid), .s1_corr(s1_corr), .s1_gain_hi(s1_gain_hi), .s1_cal(s1_cal)
    );

    gnd_accum #(.CORR_W(CORR_W), .BLOCK_LEN(BLOCK_LEN), .SUM_W(SUM_W)) u_accum (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_corr(s1_corr),
        .s1_gain_hi(s1_gain_hi), .s1_cal(s1_cal), .blk_go(blk_go), .blk_sum(blk_sum),
        .blk_cal_ok(blk_cal_ok), .blk_gain_hi(blk_gain_hi)
    );

    gnd_divider #(.SUM_W(SUM_W), .DEN(BLOCK_LEN), .OUT_W(OUT_W)) u_div (
        .clk(clk), .rst(rst), .go(blk_go), .sum(blk_sum),
        .idle(div_idle), .done(div_done), .quot(div_quot)
    );

    // calibration bookkeeping travels with the block into the divider
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cal     <= 1'b0;
            pend_gain_hi <= 1'b0;
            off_lo       <= '0;
            off_hi       <= '0;
        end else begin
            if (blk_go) begin
                pend_cal     <= blk_cal_ok;
                pend_gain_hi <= blk_gain_hi;
            end
            if (div_done && pend_cal) begin
                if (pend_gain_hi) off_hi <= div_quot;
                else              off_lo <= div_quot;
            end
        end
    end

    assign out_valid = div_done;
    assign out_data  = div_quot;
endmodule

// File: rtl/gnd_checker.sv
module gnd_checker #(
    parameter int OUT_W = 23
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data,
    input logic signed [OUT_W-1:0] off_lo,
    input logic signed [OUT_W-1:0] off_hi,
    input logic                    div_go,
    input logic                    div_idle
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_data) |-> out_valid);

    a_r7_lo_write_after_result: assert property (@(posedge clk) disable iff (rst)
        !$stable(off_lo) |-> $past(out_valid));

    a_r7_hi_write_after_result: assert property (@(posedge clk) disable iff (rst)
        !$stable(off_hi) |-> $past(out_valid));

    a_r10_handoff_to_idle: assert property (@(posedge clk) disable iff (rst)
        div_go |-> div_idle);

    a_r4_no_adjacent_blocks: assert property (@(posedge clk) disable iff (rst)
        div_go |=> !div_go);
endmodule

bind gain_norm_decim gnd_checker #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_data(out_data),
    .off_lo(off_lo), .off_hi(off_hi), .div_go(blk_go), .div_idle(div_idle)
);

// File: tb/sim_gain_norm_decim.sv
module sim_gain_norm_decim;
    localparam int  BLK   = 72;
    localparam int  LAT   = 35;
    localparam longint SMAX = 4194303;
    localparam longint SMIN = -4194304;
    // mode (0 gain1, 1 gain100, 2 alternate), cal, base, step, idle gap
    localparam int NB = 8;
    localparam int TBL [NB][5] = '{
        '{1, 0,   100,  3, 0},
        '{1, 0,    -1, -1, 0},
        '{0, 0,   -50,  1, 0},
        '{1, 1,    10,  1, 0},
        '{0, 1,    -3,  0, 0},
        '{2, 0,   500, -7, 0},
        '{2, 1,     7,  0, 0},
        '{1, 0, -1000, 11, 1}
    };

    logic clk = 0;
    logic rst;
    logic in_valid, in_gain_hi, in_cal;
    logic signed [15:0] in_sample;
    logic out_valid;
    logic signed [22:0] out_data;

    always #10 clk = ~clk;

    gain_norm_decim u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_gain_hi(in_gain_hi), .in_cal(in_cal), .out_valid(out_valid), .out_data(out_data));

    int checks = 0, errors = 0, stepn = 0, nres = 0, npush = 0;
    longint m_off [2];
    longint m_sum;
    int m_cnt;
    bit m_allcal, m_uni, m_gain;
    longint q_val [$];
    int q_due [$];
    bit q_upd [$];
    bit q_g [$];
    string q_tag [$];
    bit pend_upd; bit pend_g; longint pend_q;
    longint last_data;
    string cur_tag;

    function automatic string tag_of(int b);
        case (b)
            0: return "R2";
            1: return "R5";
            2: return "R2";
            3: return "R7";
            4: return "R7";
            5: return "R3";
            6: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic longint sat(longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic check_out();
        if (out_valid) begin
            nres++;
            checks++;
            if (q_val.size() == 0) begin
                errors++;
                $display("FAIL R6: out_valid with value %0d, expected no result", out_data);
            end else begin
                longint v = q_val.pop_front();
                int d = q_due.pop_front();
                bit u = q_upd.pop_front();
                bit g = q_g.pop_front();
                string t = q_tag.pop_front();
                if (longint'(out_data) != v || stepn != d) begin
                    errors++;
                    $display("FAIL %s: result %0d at step %0d, expected %0d at step %0d",
                             t, out_data, stepn, v, d);
                end
                if (u) begin pend_upd = 1; pend_g = g; pend_q = v; end
            end
            last_data = longint'(out_data);
        end else begin
            if (longint'(out_data) != last_data) begin
                errors++;
                $display("FAIL R6: out_data %0d changed without out_valid, expected %0d",
                         out_data, last_data);
            end
            if (q_due.size() > 0 && stepn > q_due[0]) begin
                checks++; errors++;
                $display("FAIL %s: no result by step %0d, expected %0d", q_tag[0], stepn, q_val[0]);
                void'(q_val.pop_front()); void'(q_due.pop_front());
                void'(q_upd.pop_front()); void'(q_g.pop_front()); void'(q_tag.pop_front());
            end
        end
    endtask

    task automatic step(bit v, int s, bit g, bit c);
        @(negedge clk);
        stepn++;
        check_out();
        in_valid = v; in_sample = 16'(s); in_gain_hi = g; in_cal = c;
        if (v) begin
            longint sv = longint'(signed'(16'(s)));
            longint nrm = g ? sv : sv * 100;
            longint cor = c ? nrm : nrm - m_off[g];
            if (m_cnt == 0) begin m_gain = g; m_allcal = 1; m_uni = 1; end
            m_allcal &= c;
            m_uni &= (g == m_gain);
            m_sum += cor;
            m_cnt++;
            if (m_cnt == BLK) begin
                q_val.push_back(sat(m_sum / BLK));
                q_due.push_back(stepn + LAT);
                q_upd.push_back(m_allcal && m_uni);
                q_g.push_back(m_gain);
                q_tag.push_back(cur_tag);
                npush++;
                m_sum = 0; m_cnt = 0;
            end
        end
        if (pend_upd) begin m_off[pend_g] = pend_q; pend_upd = 0; end
    endtask

    task automatic blk(bit g, bit c, int base, int stp, string t);
        cur_tag = t;
        for (int i = 0; i < BLK; i++) step(1, base + i * stp, g, c);
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 5; i++) step(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0; in_sample = 0; in_gain_hi = 0; in_cal = 0;
        repeat (3) @(negedge clk);
        m_off[0] = 0; m_off[1] = 0; m_sum = 0; m_cnt = 0; pend_upd = 0;
        q_val.delete(); q_due.delete(); q_upd.delete(); q_g.delete(); q_tag.delete();
        last_data = 0;
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1: after reset valid=%0b data=%0d, expected 0 and 0", out_valid, out_data);
        end
        rst = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; in_sample = 0; in_gain_hi = 0; in_cal = 0;
        m_off[0] = 0; m_off[1] = 0; m_sum = 0; m_cnt = 0; pend_upd = 0; last_data = 0;
        repeat (3) @(posedge clk);
        do_reset();

        // vector table, blocks back to back (R10)
        for (int b = 0; b < NB; b++) begin
            cur_tag = (b > 0) ? tag_of(b) : "R10";
            if (b > 0) cur_tag = tag_of(b);
            for (int i = 0; i < BLK; i++) begin
                bit g = (TBL[b][0] == 2) ? bit'(i % 2) : bit'(TBL[b][0]);
                step(1, TBL[b][2] + i * TBL[b][3], g, bit'(TBL[b][1]));
                if (TBL[b][4] != 0) step(0, 0, 0, 0);
            end
        end
        drain();

        // R9: clamp at both ends after learning extreme low-gain offsets
        blk(0, 1, -32768, 0, "R9");
        drain();
        blk(0, 0, 32767, 0, "R9");
        drain();
        blk(0, 1, 32767, 0, "R9");
        drain();
        blk(0, 0, -32768, 0, "R9");
        drain();

        // R1: reset in the middle of a block drops the partial sum and offsets
        cur_tag = "R1";
        for (int i = 0; i < 30; i++) step(1, 9000, 0, 0);
        do_reset();
        blk(1, 0, 5, 2, "R1");
        drain();

        checks++;
        if (nres != npush) begin
            errors++;
            $display("FAIL R4: %0d results seen, expected %0d", nres, npush);
        end
        checks++; // R6 hold between pulses is judged in check_out on every step

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule